// File: doc/BRIEF.md
# Tile-Map Background Pixel Fetcher

This block turns one screen coordinate into one background pixel. It looks the coordinate up in a tile name table held in a video RAM of 16-bit words. The first read returns a tile descriptor. That descriptor holds a tile number, two mirror bits, a two-bit palette and a priority bit. The second read returns the pattern word that carries the wanted 4-bit pixel. The result is a 6-bit colour index and a priority flag, or a transparent pixel. The renderer uses the priority flag to choose between overlapping planes.

The caller presents a coordinate with `req` while the block is idle. The block drives the video RAM read port itself, and the RAM must answer exactly one cycle after each read strobe. It then raises `pix_valid` for one cycle with the result. A small configuration register holds the name-table base field and the table-width code. A parameter selects the base granularity: 4096-word steps for a scroll plane, or 1024-word steps for the window plane.

Top module: `tilemap_pixel_fetch`

## Requirements
- R1: After synchronous reset, `busy`, `pix_valid`, `pix_color`, `pix_prio` and `vram_re` are all zero, and the configuration registers hold zero (base 0, width code 0).
- R2: The first read of a fetch goes to address base + ((y >> 3) << s) + (x >> 3), modulo 2^ADDR_W. Here s is 5, 6 or 7 for width codes 0, 1 or 3.
- R3: Width code 2 selects s = 0, so the tile row adds no offset scaled by table width.
- R4: The second read goes to (descriptor[10:0] << 4) + (py << 1) + (px >> 2), where px and py are the in-tile coordinates after mirroring.
- R5: Descriptor bit 11 replaces px = x[2:0] by 7 - x[2:0], and descriptor bit 12 replaces py = y[2:0] by 7 - y[2:0].
- R6: Bits [15:12] of the pattern word hold in-tile pixel 0 (after mirroring), bits [11:8] pixel 1, bits [7:4] pixel 2 and bits [3:0] pixel 3, within each group of four pixels.
- R7: A selected nibble of zero gives colour 0 and priority 0, whatever the descriptor holds.
- R8: A non-zero nibble gives colour {descriptor[14:13], nibble} and priority descriptor[15].
- R9: An accepted request issues the descriptor read in the accepting cycle and the pattern read in the next cycle, with no other reads. `pix_valid` rises two cycles after the pattern read and lasts exactly one cycle.
- R10: `req` is ignored while `busy` is high. No read is issued and the result in flight is unchanged.
- R11: The base address is the configuration field shifted left by 12 (scroll variant) or by 10 (window variant).
- R12: A configuration write acts from the next accepted request on. A write in the same cycle as an accepted request does not alter that request's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the configuration registers |
| cfg_base | input | FIELD_W | Name-table base field |
| cfg_size | input | 2 | Table-width code (0:32, 1:64, 2:invalid, 3:128 tiles) |
| req | input | 1 | Fetch request, taken when idle |
| px_x | input | COORD_W | Pixel column |
| px_y | input | COORD_W | Pixel row |
| vram_re | output | 1 | Video RAM read strobe |
| vram_addr | output | ADDR_W | Video RAM word address |
| vram_rdata | input | 16 | Read data, one cycle after the strobe |
| busy | output | 1 | Fetch in progress |
| pix_valid | output | 1 | Result strobe |
| pix_color | output | 6 | Palette and colour index |
| pix_prio | output | 1 | Priority flag |

## Verification
Two actions can collide in one cycle. A configuration write can land in the same cycle in which a request is accepted. The bench drives `cfg_we` and `req` on the same edge with a new base and width code. It requires that the descriptor address still follows the old settings and that the next fetch follows the new ones. A request held high throughout a fetch also meets the busy window: the bench checks that the pattern address and the result belong to the first coordinate and that no further read starts.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ATTR = 2'd1,
      ST_PAT  = 2'd2,
      ST_DONE = 2'd3
   } fetch_state_t;

   typedef struct packed {
      logic        prio;
      logic [1:0]  pal;
      logic        vflip;
      logic        hflip;
      logic [10:0] index;
   } tile_desc_t;

   // table width code to row shift; code 2 is the degenerate setting
   function automatic logic [2:0] row_shift(input logic [1:0] code);
      case (code)
         2'd0:    row_shift = 3'd5;
         2'd1:    row_shift = 3'd6;
         2'd3:    row_shift = 3'd7;
         default: row_shift = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/tmf_map_addr.sv
module tmf_map_addr #(
   parameter int ADDR_W  = 15,
   parameter int COORD_W = 10
) (
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [2:0]         shift_i,
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   output logic [ADDR_W-1:0]  addr_o
);
   logic [ADDR_W-1:0] col_w, row_w;

   assign col_w  = ADDR_W'(x_i >> 3);
   assign row_w  = ADDR_W'(y_i >> 3);
   assign addr_o = base_i + (row_w << shift_i) + col_w;
endmodule

// File: rtl/tmf_pat_addr.sv
module tmf_pat_addr
   import tmf_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  tile_desc_t        desc_i,
   input  logic [2:0]        x_lo_i,
   input  logic [2:0]        y_lo_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        sel_o
);
   logic [2:0] px, py;

   assign px     = x_lo_i ^ {3{desc_i.hflip}};
   assign py     = y_lo_i ^ {3{desc_i.vflip}};
   assign addr_o = ADDR_W'({desc_i.index, 4'b0000}) + ADDR_W'({py, px[2]});
   assign sel_o  = px[1:0];
endmodule

// File: rtl/tmf_pixel_pick.sv
module tmf_pixel_pick (
   input  logic [15:0] word_i,
   input  logic [1:0]  sel_i,
   input  logic [1:0]  pal_i,
   input  logic        prio_i,
   output logic [5:0]  color_o,
   output logic        prio_o
);
   logic [3:0] nib;

   always_comb begin
      case (sel_i)
         2'd0:    nib = word_i[15:12];
         2'd1:    nib = word_i[11:8];
         2'd2:    nib = word_i[7:4];
         default: nib = word_i[3:0];
      endcase
   end

   assign color_o = (nib == 4'd0) ? 6'd0 : {pal_i, nib};
   assign prio_o  = (nib != 4'd0) && prio_i;
endmodule

// File: rtl/tilemap_pixel_fetch.sv
module tilemap_pixel_fetch
   import tmf_pkg::*;
#(
   parameter  int ADDR_W       = 15,
   parameter  int COORD_W      = 10,
   parameter  bit WINDOW_PLANE = 1'b0,
   localparam int BASE_SHIFT   = WINDOW_PLANE ? 10 : 12,
   localparam int FIELD_W      = ADDR_W - BASE_SHIFT
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [FIELD_W-1:0] cfg_base,
   input  logic [1:0]         cfg_size,
   input  logic               req,
   input  logic [COORD_W-1:0] px_x,
   input  logic [COORD_W-1:0] px_y,
   output logic               vram_re,
   output logic [ADDR_W-1:0]  vram_addr,
   input  logic [15:0]        vram_rdata,
   output logic               busy,
   output logic               pix_valid,
   output logic [5:0]         pix_color,
   output logic               pix_prio
);
   if (ADDR_W < 15) begin : g_bad_addr
      $error("ADDR_W must be at least 15");
   end
   if (COORD_W < 4) begin : g_bad_coord
      $error("COORD_W must be at least 4");
   end

   fetch_state_t      state;
   logic [FIELD_W-1:0] base_q;
   logic [1:0]        size_q;
   logic [2:0]        x_lo_q, y_lo_q, sel_q;
   logic [1:0]        pal_q;
   logic              prio_q;
   logic [ADDR_W-1:0] base_addr, map_addr, pat_addr;
   logic [1:0]        sel_d;
   logic [5:0]        color_d;
   logic              prio_d;

   // base granularity chosen by plane variant
   if (WINDOW_PLANE) begin : g_win_base
      assign base_addr = {base_q, 10'd0};
   end else begin : g_scroll_base
      assign base_addr = {base_q, 12'd0};
   end

   tmf_map_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_map (
      .base_i (base_addr),
      .shift_i(row_shift(size_q)),
      .x_i    (px_x),
      .y_i    (px_y),
      .addr_o (map_addr)
   );

   tmf_pat_addr #(.ADDR_W(ADDR_W)) u_pat (
      .desc_i(tile_desc_t'(vram_rdata)),
      .x_lo_i(x_lo_q),
      .y_lo_i(y_lo_q),
      .addr_o(pat_addr),
      .sel_o (sel_d)
   );

   tmf_pixel_pick u_pick (
      .word_i (vram_rdata),
      .sel_i  (sel_q[1:0]),
      .pal_i  (pal_q),
      .prio_i (prio_q),
      .color_o(color_d),
      .prio_o (prio_d)
   );

   assign busy      = (state != ST_IDLE);
   assign pix_valid = (state == ST_DONE);
   assign vram_re   = ((state == ST_IDLE) && req) || (state == ST_ATTR);
   assign vram_addr = (state == ST_ATTR) ? pat_addr : map_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         base_q    <= '0;
         size_q    <= '0;
         x_lo_q    <= '0;
         y_lo_q    <= '0;
         sel_q     <= '0;
         pal_q     <= '0;
         prio_q    <= 1'b0;
         pix_color <= '0;
         pix_prio  <= 1'b0;
      end else begin
         if (cfg_we) begin
            base_q <= cfg_base;
            size_q <= cfg_size;
         end
         case (state)
            ST_IDLE: if (req) begin
               x_lo_q <= px_x[2:0];
               y_lo_q <= px_y[2:0];
               state  <= ST_ATTR;
            end
            ST_ATTR: begin
               sel_q  <= {1'b0, sel_d};
               pal_q  <= vram_rdata[14:13];
               prio_q <= vram_rdata[15];
               state  <= ST_PAT;
            end
            ST_PAT: begin
               pix_color <= color_d;
               pix_prio  <= prio_d;
               state     <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tmf_checker.sv
module tmf_checker (
   input logic       clk,
   input logic       rst,
   input logic       req,
   input logic       busy,
   input logic       vram_re,
   input logic       pix_valid,
   input logic [5:0] pix_color,
   input logic       pix_prio
);
   // R9
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      pix_valid |=> !pix_valid);

   // R9
   attr_then_pat_chk: assert property (@(posedge clk) disable iff (rst)
      (vram_re && !busy) |=> (vram_re && busy));

   // R9
   two_reads_only_chk: assert property (@(posedge clk) disable iff (rst)
      (vram_re && busy) |=> !vram_re);

   // R9
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ##2 pix_valid);

   // R10
   idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (req && !busy) |-> vram_re);

   // R7
   transparent_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && pix_color[3:0] == 4'd0) |-> (pix_color == 6'd0 && !pix_prio));
endmodule

bind tilemap_pixel_fetch tmf_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .req      (req),
   .busy     (busy),
   .vram_re  (vram_re),
   .pix_valid(pix_valid),
   .pix_color(pix_color),
   .pix_prio (pix_prio)
);

// File: tb/sim_tilemap_pixel_fetch.sv
`timescale 1ns/100ps
module sim_tilemap_pixel_fetch;
   localparam int ADDR_W  = 15;
   localparam int COORD_W = 10;
   localparam int FIELD_W = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_we = 1'b0;
   logic [FIELD_W-1:0] cfg_base = '0;
   logic [1:0] cfg_size = '0;
   logic req = 1'b0;
   logic [COORD_W-1:0] px_x = '0, px_y = '0;
   logic vram_re;
   logic [ADDR_W-1:0] vram_addr;
   logic [15:0] vram_rdata = '0;
   logic busy, pix_valid, pix_prio;
   logic [5:0] pix_color;

   int n_chk = 0;
   int n_fail = 0;
   int m_field = 0;
   int m_code = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tilemap_pixel_fetch u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .req(req), .px_x(px_x), .px_y(px_y), .vram_re(vram_re), .vram_addr(vram_addr),
      .vram_rdata(vram_rdata), .busy(busy), .pix_valid(pix_valid),
      .pix_color(pix_color), .pix_prio(pix_prio)
   );

   function automatic logic [15:0] vmem(input int a);
      int p;
      p = (a & 32'h7fff) * 40503;
      return 16'(p ^ ((a & 7) << 13) ^ (a >> 5));
   endfunction

   always @(posedge clk) if (vram_re) vram_rdata <= vmem(int'(vram_addr));

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int shift_of(input int code);
      case (code)
         0: return 5;
         1: return 6;
         3: return 7;
         default: return 0;
      endcase
   endfunction

   // one fetch; optionally hold req through busy, or write config in the accept cycle
   task automatic fetch(input int x, input int y, input bit hold,
                        input bit cfg_now, input int nf, input int nc);
      int aa, pa, attr, pw, fx, fy, nib, ecol, epri;
      aa = ((m_field << 12) + ((y >> 3) << shift_of(m_code)) + (x >> 3)) & 32'h7fff;
      attr = int'(vmem(aa));
      fx = (x & 7) ^ (((attr >> 11) & 1) * 7);
      fy = (y & 7) ^ (((attr >> 12) & 1) * 7);
      pa = (((attr & 32'h7ff) << 4) + (fy << 1) + (fx >> 2)) & 32'h7fff;
      pw = int'(vmem(pa));
      nib = (pw >> (((fx & 3) ^ 3) * 4)) & 15;
      ecol = (nib == 0) ? 0 : ((((attr >> 13) & 3) << 4) | nib);
      epri = (nib == 0) ? 0 : ((attr >> 15) & 1);

      @(negedge clk);
      req = 1'b1; px_x = COORD_W'(x); px_y = COORD_W'(y);
      if (cfg_now) begin
         cfg_we = 1'b1; cfg_base = FIELD_W'(nf); cfg_size = 2'(nc);
      end
      #1;
      chk(vram_re === 1'b1 && busy === 1'b0, "R9 accept read", {vram_re, busy}, 2);
      chk(int'(vram_addr) == aa, (m_code == 2) ? "R3 descriptor addr" : "R2 R11 descriptor addr",
          int'(vram_addr), aa);
      @(negedge clk);
      if (cfg_now) begin
         cfg_we = 1'b0; m_field = nf; m_code = nc;
      end
      if (hold) begin
         px_x = ~px_x; px_y = ~px_y;
      end else req = 1'b0;
      #1;
      chk(vram_re === 1'b1 && busy === 1'b1, "R9 pattern read", {vram_re, busy}, 3);
      chk(int'(vram_addr) == pa, "R4 R5 pattern addr", int'(vram_addr), pa);
      @(negedge clk); #1;
      chk(pix_valid === 1'b0 && vram_re === 1'b0, "R9 R10 no early result", {pix_valid, vram_re}, 0);
      @(negedge clk);
      req = 1'b0;
      #1;
      chk(pix_valid === 1'b1, "R9 valid", int'(pix_valid), 1);
      chk(int'(pix_color) == ecol, (nib == 0) ? "R7 colour" : "R6 R8 colour", int'(pix_color), ecol);
      chk(int'(pix_prio) == epri, (nib == 0) ? "R7 priority" : "R8 priority", int'(pix_prio), epri);
      @(negedge clk); #1;
      chk(pix_valid === 1'b0 && busy === 1'b0 && vram_re === 1'b0, "R9 R10 back to idle",
          {pix_valid, busy, vram_re}, 0);
   endtask

   task automatic set_cfg(input int f, input int c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_base = FIELD_W'(f); cfg_size = 2'(c);
      @(negedge clk);
      cfg_we = 1'b0; m_field = f; m_code = c;
   endtask

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(busy === 1'b0 && pix_valid === 1'b0 && vram_re === 1'b0, "R1 reset control",
          {busy, pix_valid, vram_re}, 0);
      chk(pix_color === 6'd0 && pix_prio === 1'b0, "R1 reset result", {pix_color, pix_prio}, 0);
      @(negedge clk); rst = 1'b0;
      // R1: zero config means base 0 and shift 5
      fetch(37, 29, 1'b0, 1'b0, 0, 0);
      fetch(1023, 1023, 1'b0, 1'b0, 0, 0);
      // sweep width codes, base fields and coordinates
      for (int c = 0; c < 4; c++) begin
         for (int b = 0; b < 8; b += 3) begin
            set_cfg(b, c);
            for (int yi = 0; yi < 12; yi++)
               for (int xi = 0; xi < 40; xi++)
                  fetch(xi * 3 + c * 200, yi * 5 + b * 61, 1'b0, 1'b0, 0, 0);
         end
      end
      // R10: request held through the busy window
      set_cfg(2, 1);
      fetch(100, 77, 1'b1, 1'b0, 0, 0);
      fetch(5, 900, 1'b1, 1'b0, 0, 0);
      // R12: config write in the accept cycle, then the new config applies
      fetch(250, 133, 1'b0, 1'b1, 6, 3);
      fetch(250, 133, 1'b0, 1'b0, 0, 0);
      fetch(64, 64, 1'b0, 1'b1, 1, 2);
      fetch(64, 64, 1'b0, 1'b0, 0, 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule